// File: doc/BRIEF.md
# Bisecting Disk Geometry Prober

This block works out how many heads, cylinders and sectors per track a drive has when nothing else can report them. It sends a series of seek requests to the command sequencer beside it. Each reply says whether the seek succeeded, and the block uses that answer to narrow down the real size of the drive.

The block searches one dimension at a time: heads first, then cylinders, then sectors. For each dimension it keeps a lower bound `lo`, which is a value known to be reachable, and an upper bound `hi`, which is a value known to be out of range. It always probes the midpoint. Once `hi` is exactly one above `lo`, that dimension is fixed at `lo` and stays there in every later request. The geometry is then reported as `lo + 1` for each dimension, and a one-cycle done pulse marks the end of the search.

A start pulse begins a search at any time. It discards whatever search is in progress.

Top module: `geo_prober`

## Requirements
- R1: After reset, no request is pending, done is low, and all three geometry outputs read 1.
- R2: A start resets the ranges to [0, HEAD_LIM), [0, CYL_LIM) and [0, SECT_LIM). The first request after a start is therefore (HEAD_LIM/2, 0, 0), which is (8, 0, 0) with the default parameters.
- R3: The probe value is always floor((lo + hi) / 2) of the dimension being searched. A successful reply sets lo to the probe, and a failed reply sets hi to the probe.
- R4: The dimensions are searched in the order heads, cylinders, sectors. A dimension that is already fixed carries its final lo in every later request, and a dimension not yet reached carries 0.
- R5: While a request is pending without a reply, its valid flag and all three fields stay constant.
- R6: When the sector dimension fixes, done is high for exactly one cycle. At that moment each geometry output equals its dimension's final lo + 1, which is the drive's real count when a seek succeeds only inside the drive's bounds.
- R7: A start pulse during a search abandons that search and restarts from the initial ranges. A reply that arrives while no request is pending changes nothing.
- R8: A reply clears the pending request, and the request flag is low in the cycle that follows the reply.
- R9: When all three limits are powers of two, a search issues exactly log2(HEAD_LIM) + log2(CYL_LIM) + log2(SECT_LIM) requests, whatever the drive. This is 20 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins or restarts a search |
| req_valid_o | output | 1 | A seek request is pending |
| req_head_o | output | $clog2(HEAD_LIM) | Head field of the seek |
| req_cyl_o | output | $clog2(CYL_LIM) | Cylinder field of the seek |
| req_sect_o | output | $clog2(SECT_LIM) | Sector field of the seek |
| rsp_valid_i | input | 1 | Reply strobe for the pending request |
| rsp_ok_i | input | 1 | 1 means the seek succeeded, 0 means it failed |
| done_o | output | 1 | One-cycle pulse when the search completes |
| geo_heads_o | output | $clog2(HEAD_LIM+1) | Head count found (lo + 1) |
| geo_cyls_o | output | $clog2(CYL_LIM+1) | Cylinder count found (lo + 1) |
| geo_sects_o | output | $clog2(SECT_LIM+1) | Sectors per track found (lo + 1) |

## Verification
The assertions check the handshake rules on every cycle: a pending request holds steady, a reply always leaves a gap cycle before the next request, done lasts a single cycle and is followed by silence, a start clears the pending request, and the reported counts stay within their limits. The bench's scenarios show the parts no single cycle can reveal. These are the exact midpoint sequence, the heads-cylinders-sectors order with fixed and zeroed fields, the final counts against a modelled drive (including the smallest and largest geometries), the total number of requests, an abort part way through a search, and a stray reply while idle.

// File: rtl/geo_pkg.sv
package geo_pkg;

   localparam int unsigned GEO_DIMS = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CALC = 2'd1,
      ST_WAIT = 2'd2
   } geo_state_e;

endpackage

// File: rtl/geo_bisect_lane.sv
// One search dimension: holds the known-good lower bound, the known-bad
// upper bound and the value currently probed.
module geo_bisect_lane #(
   parameter int unsigned LIMIT = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         init_i,
   input  logic                         load_i,
   input  logic                         upd_i,
   input  logic                         ok_i,
   input  logic                         fix_i,
   output logic                         conv_o,
   output logic [$clog2(LIMIT)-1:0]     test_o,
   output logic [$clog2(LIMIT+1)-1:0]   count_o
);

   localparam int unsigned TW = $clog2(LIMIT);
   localparam int unsigned RW = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("geo_bisect_lane: LIMIT must be at least 2");
   end

   logic [RW-1:0] lo_q;
   logic [RW-1:0] hi_q;
   logic [TW-1:0] probe_q;

   always_ff @(posedge clk) begin
      if (!rst_n || init_i) begin
         lo_q    <= '0;
         hi_q    <= RW'(LIMIT);
         probe_q <= '0;
      end else if (load_i) begin
         probe_q <= TW'(({1'b0, lo_q} + {1'b0, hi_q}) >> 1);
      end else if (upd_i) begin
         if (ok_i) lo_q <= RW'(probe_q);
         else      hi_q <= RW'(probe_q);
      end else if (fix_i) begin
         probe_q <= TW'(lo_q);
      end
   end

   assign conv_o  = ((lo_q + RW'(1)) == hi_q);
   assign count_o = lo_q + RW'(1);
   assign test_o  = probe_q;

endmodule

// File: rtl/geo_probe_seq.sv
// Walks the dimensions in order and paces the request/reply handshake.
module geo_probe_seq
   import geo_pkg::*;
#(
   parameter int unsigned NDIM = GEO_DIMS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            rsp_valid_i,
   input  logic [NDIM-1:0] conv_i,
   output logic            init_o,
   output logic [NDIM-1:0] load_o,
   output logic [NDIM-1:0] upd_o,
   output logic [NDIM-1:0] fix_o,
   output logic            req_valid_o,
   output logic            done_o
);

   localparam int unsigned DW = (NDIM > 1) ? $clog2(NDIM) : 1;

   if (NDIM < 1) begin : g_bad_ndim
      $error("geo_probe_seq: NDIM must be at least 1");
   end

   geo_state_e    state_q, state_d;
   logic [DW-1:0] dim_q, dim_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dim_q   <= '0;
      end else begin
         state_q <= state_d;
         dim_q   <= dim_d;
      end
   end

   always_comb begin
      state_d = state_q;
      dim_d   = dim_q;
      init_o  = 1'b0;
      load_o  = '0;
      upd_o   = '0;
      fix_o   = '0;
      done_o  = 1'b0;
      if (start_i) begin
         init_o  = 1'b1;
         state_d = ST_CALC;
         dim_d   = '0;
      end else begin
         case (state_q)
            ST_CALC: begin
               if (conv_i[dim_q]) begin
                  fix_o[dim_q] = 1'b1;
                  if (dim_q == DW'(NDIM - 1)) begin
                     done_o  = 1'b1;
                     state_d = ST_IDLE;
                  end else begin
                     dim_d = DW'(dim_q + 1'b1);
                  end
               end else begin
                  load_o[dim_q] = 1'b1;
                  state_d       = ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (rsp_valid_i) begin
                  upd_o[dim_q] = 1'b1;
                  state_d      = ST_CALC;
               end
            end
            default: ;
         endcase
      end
   end

   assign req_valid_o = (state_q == ST_WAIT);

endmodule

// File: rtl/geo_prober.sv
module geo_prober
   import geo_pkg::*;
#(
   parameter int unsigned HEAD_LIM = 16,
   parameter int unsigned CYL_LIM  = 1024,
   parameter int unsigned SECT_LIM = 64
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   output logic                          req_valid_o,
   output logic [$clog2(HEAD_LIM)-1:0]   req_head_o,
   output logic [$clog2(CYL_LIM)-1:0]    req_cyl_o,
   output logic [$clog2(SECT_LIM)-1:0]   req_sect_o,
   input  logic                          rsp_valid_i,
   input  logic                          rsp_ok_i,
   output logic                          done_o,
   output logic [$clog2(HEAD_LIM+1)-1:0] geo_heads_o,
   output logic [$clog2(CYL_LIM+1)-1:0]  geo_cyls_o,
   output logic [$clog2(SECT_LIM+1)-1:0] geo_sects_o
);

   logic                lane_init;
   logic [GEO_DIMS-1:0] lane_load;
   logic [GEO_DIMS-1:0] lane_upd;
   logic [GEO_DIMS-1:0] lane_fix;
   logic [GEO_DIMS-1:0] lane_conv;

   geo_probe_seq #(.NDIM(GEO_DIMS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .rsp_valid_i (rsp_valid_i),
      .conv_i      (lane_conv),
      .init_o      (lane_init),
      .load_o      (lane_load),
      .upd_o       (lane_upd),
      .fix_o       (lane_fix),
      .req_valid_o (req_valid_o),
      .done_o      (done_o)
   );

   for (genvar g = 0; g < GEO_DIMS; g++) begin : g_dim
      if (g == 0) begin : g_head
         geo_bisect_lane #(.LIMIT(HEAD_LIM)) u_lane (
            .clk(clk), .rst_n(rst_n), .init_i(lane_init),
            .load_i(lane_load[g]), .upd_i(lane_upd[g]), .ok_i(rsp_ok_i),
            .fix_i(lane_fix[g]), .conv_o(lane_conv[g]),
            .test_o(req_head_o), .count_o(geo_heads_o)
         );
      end else if (g == 1) begin : g_cyl
         geo_bisect_lane #(.LIMIT(CYL_LIM)) u_lane (
            .clk(clk), .rst_n(rst_n), .init_i(lane_init),
            .load_i(lane_load[g]), .upd_i(lane_upd[g]), .ok_i(rsp_ok_i),
            .fix_i(lane_fix[g]), .conv_o(lane_conv[g]),
            .test_o(req_cyl_o), .count_o(geo_cyls_o)
         );
      end else begin : g_sect
         geo_bisect_lane #(.LIMIT(SECT_LIM)) u_lane (
            .clk(clk), .rst_n(rst_n), .init_i(lane_init),
            .load_i(lane_load[g]), .upd_i(lane_upd[g]), .ok_i(rsp_ok_i),
            .fix_i(lane_fix[g]), .conv_o(lane_conv[g]),
            .test_o(req_sect_o), .count_o(geo_sects_o)
         );
      end
   end

endmodule

// File: rtl/geo_prober_chk.sv
module geo_prober_chk #(
   parameter int unsigned HEAD_LIM = 16,
   parameter int unsigned CYL_LIM  = 1024,
   parameter int unsigned SECT_LIM = 64
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          start_i,
   input logic                          req_valid_o,
   input logic [$clog2(HEAD_LIM)-1:0]   req_head_o,
   input logic [$clog2(CYL_LIM)-1:0]    req_cyl_o,
   input logic [$clog2(SECT_LIM)-1:0]   req_sect_o,
   input logic                          rsp_valid_i,
   input logic                          done_o,
   input logic [$clog2(HEAD_LIM+1)-1:0] geo_heads_o,
   input logic [$clog2(CYL_LIM+1)-1:0]  geo_cyls_o,
   input logic [$clog2(SECT_LIM+1)-1:0] geo_sects_o
);

   p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && !rsp_valid_i && !start_i |=>
         req_valid_o && $stable(req_head_o) && $stable(req_cyl_o) && $stable(req_sect_o));

   p_gap_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && rsp_valid_i && !start_i |=> !req_valid_o);

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_geo_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (geo_heads_o >= 1) && (32'(geo_heads_o) <= HEAD_LIM) &&
                 (geo_cyls_o  >= 1) && (32'(geo_cyls_o)  <= CYL_LIM)  &&
                 (geo_sects_o >= 1) && (32'(geo_sects_o) <= SECT_LIM));

   p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> !req_valid_o);

   p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !req_valid_o && !done_o);

endmodule

bind geo_prober geo_prober_chk #(
   .HEAD_LIM(HEAD_LIM), .CYL_LIM(CYL_LIM), .SECT_LIM(SECT_LIM)
) chk_i (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_valid_o(req_valid_o),
   .req_head_o(req_head_o), .req_cyl_o(req_cyl_o), .req_sect_o(req_sect_o),
   .rsp_valid_i(rsp_valid_i), .done_o(done_o), .geo_heads_o(geo_heads_o),
   .geo_cyls_o(geo_cyls_o), .geo_sects_o(geo_sects_o)
);

// File: tb/geo_prober_tb_top.sv
module geo_prober_tb_top;

   localparam int HL = 16;
   localparam int CL = 1024;
   localparam int SL = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic rsp_valid_i = 1'b0;
   logic rsp_ok_i = 1'b0;
   logic req_valid_o, done_o;
   logic [3:0]  req_head_o;
   logic [9:0]  req_cyl_o;
   logic [5:0]  req_sect_o;
   logic [4:0]  geo_heads_o;
   logic [10:0] geo_cyls_o;
   logic [6:0]  geo_sects_o;

   always #5 clk = ~clk;

   geo_prober #(.HEAD_LIM(HL), .CYL_LIM(CL), .SECT_LIM(SL)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_valid_o(req_valid_o),
      .req_head_o(req_head_o), .req_cyl_o(req_cyl_o), .req_sect_o(req_sect_o),
      .rsp_valid_i(rsp_valid_i), .rsp_ok_i(rsp_ok_i), .done_o(done_o),
      .geo_heads_o(geo_heads_o), .geo_cyls_o(geo_cyls_o), .geo_sects_o(geo_sects_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int lo_m[3];
   int hi_m[3];
   int dm;
   int truth[3];
   int lims[3] = '{HL, CL, SL};

   task automatic check(input bit cond, input string tag, input int act, input int exp);
      n_cmp++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int seek_ok(input int h, input int c, input int s);
      return (h < truth[0] && c < truth[1] && s < truth[2]) ? 1 : 0;
   endfunction

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      for (int d = 0; d < 3; d++) begin
         lo_m[d] = 0;
         hi_m[d] = lims[d];
      end
      dm = 0;
   endtask

   // Runs one search against a modelled drive; abort_at > 0 stops after that request.
   task automatic run_probe(input int h, input int c, input int s, input int abort_at);
      int nreq = 0;
      int e[3];
      truth[0] = h; truth[1] = c; truth[2] = s;
      pulse_start();
      while (1) begin
         if (done_o) begin
            check(lo_m[2] + 1 == hi_m[2], "R6 done only after sectors fix", lo_m[2], hi_m[2] - 1);
            check(int'(geo_heads_o) == h, "R6 heads", int'(geo_heads_o), h);
            check(int'(geo_cyls_o) == c, "R6 cylinders", int'(geo_cyls_o), c);
            check(int'(geo_sects_o) == s, "R6 sectors", int'(geo_sects_o), s);
            check(nreq == 20, "R9 request count", nreq, 20);
            @(negedge clk);
            check(!done_o, "R6 done one cycle", int'(done_o), 0);
            return;
         end
         if (req_valid_o) begin
            nreq++;
            while (dm < 2 && lo_m[dm] + 1 == hi_m[dm]) dm++;
            for (int d = 0; d < 3; d++)
               e[d] = (d < dm) ? lo_m[d] : (d == dm) ? (lo_m[d] + hi_m[d]) / 2 : 0;
            if (nreq == 1)
               check(int'(req_head_o) == HL / 2 && req_cyl_o == 0 && req_sect_o == 0,
                     "R2 first request", int'(req_head_o), HL / 2);
            check(int'(req_head_o) == e[0], "R3 R4 head field", int'(req_head_o), e[0]);
            check(int'(req_cyl_o) == e[1], "R3 R4 cylinder field", int'(req_cyl_o), e[1]);
            check(int'(req_sect_o) == e[2], "R3 R4 sector field", int'(req_sect_o), e[2]);
            if (nreq == abort_at) return;
            begin
               int dly = int'($urandom_range(0, 3));
               for (int k = 0; k < dly; k++) begin
                  @(negedge clk);
                  check(req_valid_o && int'(req_cyl_o) == e[1] && int'(req_head_o) == e[0]
                        && int'(req_sect_o) == e[2], "R5 request held", int'(req_valid_o), 1);
               end
            end
            rsp_valid_i = 1'b1;
            rsp_ok_i    = seek_ok(e[0], e[1], e[2]) != 0;
            if (rsp_ok_i) lo_m[dm] = e[dm];
            else          hi_m[dm] = e[dm];
            @(negedge clk);
            rsp_valid_i = 1'b0;
            rsp_ok_i    = 1'($urandom_range(0, 1));
            check(!req_valid_o, "R8 gap after reply", int'(req_valid_o), 0);
         end else begin
            @(negedge clk);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(!req_valid_o, "R1 no request in reset", int'(req_valid_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!req_valid_o && !done_o, "R1 idle after reset", int'(req_valid_o), 0);
      check(geo_heads_o == 1 && geo_cyls_o == 1 && geo_sects_o == 1,
            "R1 outputs read 1", int'(geo_heads_o), 1);

      run_probe(1, 1, 1, 0);
      run_probe(HL, CL, SL, 0);
      run_probe(5, 300, 17, 0);
      run_probe(16, 1, 64, 0);
      run_probe(1, 1024, 1, 0);

      // R7: abort in the cylinder phase, then restart cleanly
      run_probe(9, 700, 33, 7);
      run_probe(3, 615, 26, 0);

      // R7: stray reply while idle changes nothing
      @(negedge clk);
      rsp_valid_i = 1'b1;
      rsp_ok_i    = 1'b1;
      @(negedge clk);
      rsp_valid_i = 1'b0;
      for (int k = 0; k < 3; k++) begin
         check(!req_valid_o && !done_o, "R7 idle reply ignored", int'(req_valid_o), 0);
         check(geo_heads_o == 3 && geo_cyls_o == 615 && geo_sects_o == 26,
               "R7 results unchanged", int'(geo_cyls_o), 615);
         @(negedge clk);
      end

      for (int t = 0; t < 8; t++)
         run_probe(int'($urandom_range(1, HL)), int'($urandom_range(1, CL)),
                   int'($urandom_range(1, SL)), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule